// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Engine

This block sits behind a two-wire serial memory front end. The protocol sequencer loads a start word address and then passes each received data byte. The block keeps those bytes in a page latch of 16 slots, selected by the low four address bits. When a stop condition follows at least one complete data byte, the block starts a write cycle. During the cycle it copies the buffered bytes into a 1024 x 8 storage array, one slot per clock, and it holds a busy flag for a programmable number of system clocks.

The block enforces the write-protect rules. A protect level seen before the first data bit is sampled has no effect. A protect level seen from that sample to the stop cancels the command. A protect level seen during the busy time ends the cycle at once. A low-supply flag blocks every array update. Reads work at all times through a combinational port.

Top module: `pgw_engine`

## Requirements
- R1: After reset, every array location reads FFh and busy_o is low.
- R2: A stop_i pulse commits the command when three conditions hold: at least one byte was received since the last address load, no cancel is pending, and wp_i and lowv_i are low. busy_o rises in the cycle after the stop and stays high for exactly WR_CYCLES cycles. No cycle starts from a single write per byte.
- R3: The slot pointer starts at address bits 3:0 and only those bits increment, wrapping from 15 to 0. Bits 9:4 stay fixed for the whole page. A page started at 20Eh writes 20Eh, 20Fh, 200h, 201h.
- R4: When more than 16 bytes arrive, the pointer wraps and later bytes overwrite the earlier slots. Byte 17 lands at the start slot.
- R5: Only slots that received a byte are written. Other locations in the page keep their contents. Every address load clears the record of received slots.
- R6: A stop with no data byte since the last address load starts no write cycle and changes no location.
- R7: wp_i high before the first d0_stb_i of a command has no effect on that command.
- R8: wp_i high in any cycle from the first d0_stb_i up to and including the stop cancels the command. busy_o stays low and no location changes.
- R9: wp_i high while busy_o is high drops busy_o in the next cycle. Locations outside the active page are unchanged.
- R10: lowv_i high at the stop starts no cycle. lowv_i high during the busy time blocks all array updates.
- R11: addr_load_i, byte_stb_i, d0_stb_i and stop_i are ignored while busy_o is high.
- R12: rd_data_o returns the array content at rd_addr_i in the same cycle. This holds while busy and while wp_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Start-address load strobe for a new write command |
| addr_i | input | 10 | Start word address |
| byte_stb_i | input | 1 | A complete data byte has been received |
| byte_i | input | 8 | Received data byte |
| d0_stb_i | input | 1 | Strobe at the clock edge that samples the last bit of a data byte |
| stop_i | input | 1 | Stop condition seen |
| wp_i | input | 1 | Write-protect level |
| lowv_i | input | 1 | Low-supply flag |
| busy_o | output | 1 | Write cycle in progress |
| rd_addr_i | input | 10 | Read address |
| rd_data_o | output | 8 | Read data |

## Verification
The assertions check on every cycle that a busy period ends either after exactly the programmed length or one cycle after protect rises. They also check that busy only rises after a stop with protect and low supply both low, and that no array write is issued outside busy or while protect or low supply is high. The placement of data can only be shown by the bench scenarios: wrap within the page, overwrite on overflow, partial pages, and commands ignored during busy. The same holds for the cancel window around the first data bit and for array contents after an abort.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned ADDR_W_D    = 10;
  localparam int unsigned PAGE_W_D    = 4;
  localparam int unsigned DATA_W_D    = 8;
  localparam int unsigned WR_CYCLES_D = 40;
  localparam logic [7:0]  ERASED      = 8'hFF;
endpackage

// File: rtl/pgw_page_latch.sv
module pgw_page_latch #(
  parameter int unsigned ADDR_W = pgw_pkg::ADDR_W_D,
  parameter int unsigned PAGE_W = pgw_pkg::PAGE_W_D,
  parameter int unsigned DATA_W = pgw_pkg::DATA_W_D,
  localparam int unsigned SLOTS = 1 << PAGE_W,
  localparam int unsigned HI_W  = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_stb_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              d0_stb_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              lowv_i,
  input  logic [PAGE_W-1:0] slot_i,
  output logic              commit_o,
  output logic [HI_W-1:0]   base_o,
  output logic [DATA_W-1:0] slot_data_o,
  output logic              slot_vld_o
);
  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;
  logic [HI_W-1:0]   base_q;
  logic [PAGE_W-1:0] ptr_q;
  logic              armed_q, win_q, cancel_q;
  logic              take_byte;

  assign take_byte = byte_stb_i & ~busy_i & ~addr_load_i;
  assign commit_o  = stop_i & ~busy_i & armed_q & ~cancel_q & ~wp_i & ~lowv_i;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        data_q[s] <= '0;
      else if (take_byte && ptr_q == PAGE_W'(s))          data_q[s] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      base_q   <= '0;
      ptr_q    <= '0;
      armed_q  <= 1'b0;
      win_q    <= 1'b0;
      cancel_q <= 1'b0;
    end else if (!busy_i) begin
      if (addr_load_i) begin
        base_q   <= addr_i[ADDR_W-1:PAGE_W];
        ptr_q    <= addr_i[PAGE_W-1:0];
        vld_q    <= '0;
        armed_q  <= 1'b0;
        win_q    <= 1'b0;
        cancel_q <= 1'b0;
      end else begin
        // cancel window opens at the first D0 sample edge
        cancel_q <= cancel_q | (wp_i & (win_q | d0_stb_i));
        if (d0_stb_i) win_q <= 1'b1;
        if (take_byte) begin
          vld_q[ptr_q] <= 1'b1;
          ptr_q        <= ptr_q + 1'b1;
          armed_q      <= 1'b1;
        end
        if (commit_o) armed_q <= 1'b0;
      end
    end
  end

  assign base_o      = base_q;
  assign slot_data_o = data_q[slot_i];
  assign slot_vld_o  = vld_q[slot_i];
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
  parameter int unsigned WR_CYCLES = pgw_pkg::WR_CYCLES_D,
  parameter int unsigned PAGE_W    = pgw_pkg::PAGE_W_D,
  localparam int unsigned CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              wp_i,
  input  logic              lowv_i,
  input  logic              slot_vld_i,
  output logic              busy_o,
  output logic [PAGE_W-1:0] slot_o,
  output logic              we_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PAGE_W:0]  idx_q;
  logic             busy_q;

  // one slot per clock from the start of busy; WR_CYCLES must cover all slots
  assign we_o   = busy_q & ~idx_q[PAGE_W] & slot_vld_i & ~wp_i & ~lowv_i;
  assign slot_o = idx_q[PAGE_W-1:0];
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (commit_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WR_CYCLES - 1);
      idx_q  <= '0;
    end else if (busy_q) begin
      if (wp_i)              busy_q <= 1'b0;
      else if (cnt_q == '0)  busy_q <= 1'b0;
      else                   cnt_q  <= cnt_q - 1'b1;
      if (!idx_q[PAGE_W])    idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int unsigned ADDR_W = pgw_pkg::ADDR_W_D,
  parameter int unsigned DATA_W = pgw_pkg::DATA_W_D,
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= DATA_W'(pgw_pkg::ERASED);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pgw_engine.sv
module pgw_engine #(
  parameter int unsigned ADDR_W    = pgw_pkg::ADDR_W_D,
  parameter int unsigned PAGE_W    = pgw_pkg::PAGE_W_D,
  parameter int unsigned DATA_W    = pgw_pkg::DATA_W_D,
  parameter int unsigned WR_CYCLES = pgw_pkg::WR_CYCLES_D,
  localparam int unsigned HI_W     = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_stb_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              d0_stb_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              lowv_i,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              commit, slot_vld, arr_we;
  logic [HI_W-1:0]   base;
  logic [PAGE_W-1:0] slot;
  logic [DATA_W-1:0] slot_data;

  pgw_page_latch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_latch (
    .clk_i, .rst_ni, .busy_i(busy_o), .addr_load_i, .addr_i, .byte_stb_i, .byte_i,
    .d0_stb_i, .stop_i, .wp_i, .lowv_i, .slot_i(slot), .commit_o(commit),
    .base_o(base), .slot_data_o(slot_data), .slot_vld_o(slot_vld)
  );

  pgw_cycle_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk_i, .rst_ni, .commit_i(commit), .wp_i, .lowv_i, .slot_vld_i(slot_vld),
    .busy_o, .slot_o(slot), .we_o(arr_we)
  );

  pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni, .we_i(arr_we), .waddr_i({base, slot}), .wdata_i(slot_data),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int unsigned WR_CYC = pgw_pkg::WR_CYCLES_D
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_i,
  input logic wp_i,
  input logic lowv_i,
  input logic busy_i,
  input logic we_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_i) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && !$past(wp_i)) |-> (run_q == WR_CYC)); // R2
  AST_WP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wp_i) |=> !busy_i); // R9
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(stop_i) && !$past(wp_i) && !$past(lowv_i))); // R8
  AST_NO_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i || lowv_i) |-> !we_i); // R10
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !we_i); // R11
endmodule

bind pgw_engine pgw_checker #(.WR_CYC(WR_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .wp_i(wp_i), .lowv_i(lowv_i),
  .busy_i(busy_o), .we_i(arr_we)
);

// File: tb/sim_pgw_engine.sv
`timescale 1ns/1ps
module sim_pgw_engine;
  localparam int WR = 40;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, byte_stb = 0, d0_stb = 0, stop = 0, wp = 0, lowv = 0;
  logic [9:0] addr = 0, rd_addr = 0;
  logic [7:0] bdata = 0;
  logic busy;
  logic [7:0] rd_data;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pgw_engine #(.WR_CYCLES(WR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .addr_i(addr),
    .byte_stb_i(byte_stb), .byte_i(bdata), .d0_stb_i(d0_stb), .stop_i(stop),
    .wp_i(wp), .lowv_i(lowv), .busy_o(busy), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // behavioural reference
  int m_mem [1024];
  int p_data [16];
  bit p_vld [16];
  bit excl [64];
  bit m_busy, armed, win, cancel, lv_any, lv_all;
  int m_left, base, ptr, m_page;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 'hFF;
      foreach (excl[i]) excl[i] = 0;
      m_busy = 0; armed = 0; win = 0; cancel = 0; ptr = 0; base = 0;
    end else if (m_busy) begin
      if (wp) begin
        m_busy = 0; excl[m_page] = 1;
      end else begin
        lv_any |= lowv; lv_all &= lowv;
        if (m_left == 1) begin
          m_busy = 0;
          if (!lv_any) begin
            for (int s = 0; s < 16; s++) if (p_vld[s]) m_mem[m_page*16+s] = p_data[s];
          end else if (!lv_all) excl[m_page] = 1;
        end else m_left--;
      end
    end else begin
      if (addr_load) begin
        base = addr / 16; ptr = addr % 16; armed = 0; win = 0; cancel = 0;
        for (int s = 0; s < 16; s++) p_vld[s] = 0;
      end else begin
        if (wp && (win || d0_stb)) cancel = 1;
        if (d0_stb) win = 1;
        if (byte_stb) begin
          p_data[ptr] = bdata; p_vld[ptr] = 1; ptr = (ptr + 1) % 16; armed = 1;
        end
        if (stop && armed && !cancel && !wp && !lowv) begin
          m_busy = 1; m_left = WR; m_page = base; lv_any = 0; lv_all = 1; armed = 0;
        end
      end
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      total++;
      if (busy !== m_busy) begin
        bad++; $display("FAIL R2 busy per-cycle actual=%0b expected=%0b", busy, m_busy);
      end
      if (!excl[rd_addr/16] && !(m_busy && rd_addr/16 == m_page)) begin
        total++;
        if (rd_data !== m_mem[rd_addr][7:0]) begin
          bad++; $display("FAIL R12 read %03h actual=%02h expected=%02h", rd_addr, rd_data, m_mem[rd_addr][7:0]);
        end
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic load(logic [9:0] a);
    @(negedge clk) addr_load = 1; addr = a; @(negedge clk) addr_load = 0;
  endtask
  task automatic send(logic [7:0] b);
    @(negedge clk) d0_stb = 1; @(negedge clk) d0_stb = 0; byte_stb = 1; bdata = b;
    @(negedge clk) byte_stb = 0;
  endtask
  task automatic do_stop; @(negedge clk) stop = 1; @(negedge clk) stop = 0; endtask
  task automatic wait_idle; for (int i = 0; i < 200 && busy; i++) @(negedge clk); cyc(1); endtask
  task automatic chk(logic [9:0] a, logic [7:0] e, string tag);
    @(negedge clk) rd_addr = a; #2;
    total++;
    if (rd_data !== e) begin
      bad++; $display("FAIL %s addr=%03h actual=%02h expected=%02h", tag, a, rd_data, e);
    end
  endtask
  task automatic chk_bit(logic act, logic e, string tag);
    total++;
    if (act !== e) begin bad++; $display("FAIL %s actual=%0b expected=%0b", tag, act, e); end
  endtask
  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    bad++; $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    int n;
    cyc(3); rst_n = 1; cyc(2);
    // R1
    chk(10'h000, 8'hFF, "R1"); chk(10'h3FF, 8'hFF, "R1"); chk_bit(busy, 0, "R1 busy");
    // R2 single byte and busy length
    load(10'h123); send(8'h5A); do_stop();
    n = busy ? 1 : 0;
    while (busy && n < 200) begin @(negedge clk); if (busy) n++; end
    total++; if (n != WR) begin bad++; $display("FAIL R2 busy length actual=%0d expected=%0d", n, WR); end
    cyc(1); chk(10'h123, 8'h5A, "R2");
    // R3 wrap in page
    load(10'h20E); send(8'h11); send(8'h22); send(8'h33); send(8'h44); do_stop(); wait_idle();
    chk(10'h20E, 8'h11, "R3"); chk(10'h20F, 8'h22, "R3"); chk(10'h200, 8'h33, "R3");
    chk(10'h201, 8'h44, "R3"); chk(10'h210, 8'hFF, "R3 upper fixed");
    // R4 overflow
    load(10'h300); for (int i = 0; i < 18; i++) send(8'h80 + 8'(i)); do_stop(); wait_idle();
    chk(10'h300, 8'h90, "R4"); chk(10'h301, 8'h91, "R4"); chk(10'h302, 8'h82, "R4"); chk(10'h30F, 8'h8F, "R4");
    // R5 partial page
    load(10'h045); send(8'hA1); send(8'hA2); do_stop(); wait_idle();
    chk(10'h045, 8'hA1, "R5"); chk(10'h046, 8'hA2, "R5"); chk(10'h044, 8'hFF, "R5"); chk(10'h047, 8'hFF, "R5");
    load(10'h047); send(8'hA3); do_stop(); wait_idle();
    chk(10'h045, 8'hA1, "R5 mask cleared"); chk(10'h047, 8'hA3, "R5");
    // R6 stop with no data
    load(10'h050); do_stop(); @(negedge clk); chk_bit(busy, 0, "R6 busy"); chk(10'h050, 8'hFF, "R6");
    // R7 wp before first D0 ignored
    @(negedge clk) wp = 1; load(10'h070); @(negedge clk) wp = 0; send(8'h3C); do_stop(); wait_idle();
    chk(10'h070, 8'h3C, "R7");
    // R8 wp after D0 cancels
    load(10'h060); send(8'hC3); @(negedge clk) wp = 1; @(negedge clk) wp = 0; do_stop();
    @(negedge clk); chk_bit(busy, 0, "R8 busy"); chk(10'h060, 8'hFF, "R8");
    // R9 abort during busy
    load(10'h370); for (int i = 0; i < 16; i++) send(8'h10 + 8'(i)); do_stop(); cyc(5);
    @(negedge clk) wp = 1; @(negedge clk) wp = 0;
    chk_bit(busy, 0, "R9 busy dropped");
    chk(10'h123, 8'h5A, "R9 outside"); chk(10'h380, 8'hFF, "R9 outside"); chk(10'h36F, 8'hFF, "R9 outside");
    // R10 low supply
    load(10'h0A0); send(8'h55); @(negedge clk) lowv = 1; do_stop(); @(negedge clk);
    chk_bit(busy, 0, "R10 stop"); lowv = 0;
    load(10'h0A0); send(8'h55); do_stop(); lowv = 1; wait_idle(); lowv = 0;
    chk(10'h0A0, 8'hFF, "R10 busy inhibit");
    // R11 commands ignored while busy; R12 read while busy
    load(10'h0B0); send(8'h77); do_stop();
    load(10'h0C0); send(8'h66); do_stop();
    chk(10'h123, 8'h5A, "R12 read busy"); chk_bit(busy, 1, "R12 still busy");
    wait_idle(); cyc(3);
    chk_bit(busy, 0, "R11 no second cycle"); chk(10'h0B0, 8'h77, "R11"); chk(10'h0C0, 8'hFF, "R11");
    @(negedge clk) wp = 1; chk(10'h0B0, 8'h77, "R12 read wp"); @(negedge clk) wp = 0;
    cyc(3);
    report();
  end
endmodule